// File: doc/BRIEF.md
# Display Link Ultra-Low-Power Entry Sequencer

This block walks a serial display host and its PHY into ultra-low-power mode on the clock lane and on one or two data lanes. Software pulses a request. The sequencer then confirms that the link is in a clean stop state with the PLL locked. It moves the byte-clock source over to a system-generated clock and waits for the clock mux to confirm the switch. After that it issues the lane power-down request and watches the PHY status until every active lane reports that it has entered the mode.

When entry is complete, the PHY PLL is turned off, unless a keep-PLL option asks for the faster path that leaves it running. The block then pulses done. It flags an error if a precondition fails or if the lanes do not respond within a programmable number of cycles. After an error it freezes its outputs until reset.

Top module: `ulp_entry_seq`

## Requirements
- R1: Reset state: while reset is held and on the first cycle after it, byteclk_sel = 0, ulp_req = 4'h0, done = 0 and err = 0. pll_en and reg_en take the values of pll_en_rst and reg_en_rst.
- R2: A request taken in idle first checks the preconditions: clk_ctl = 2'b11, pll_en = 1, reg_en = 1, ulp_req = 4'h0 and trig = 4'h0. If any of them fails, err rises with err_tmo = 0, and byteclk_sel and ulp_req keep their values.
- R3: The stop-state precondition depends on the lane count. With two_lane = 0 it needs stat[6:4] = 3'b011. With two_lane = 1 it needs stat[8:4] = 5'b11011. Both cases also need stat[1] = 0 and pll_lock = 1. A mismatch gives the same error as R2.
- R4: Once the preconditions pass, byteclk_sel goes to 1 while ulp_req is still 4'h0. ulp_req becomes 4'h5 at the first clock edge that samples mux_ack high, and never before.
- R5: Lane entry is complete when stat[6:1] = 0 with two_lane = 0, where stat[8:7] is ignored. With two_lane = 1 it is complete when stat[8:1] = 0.
- R6: With keep_pll = 0, pll_en drops to 0 after entry completes and before done. With keep_pll = 1, pll_en stays 1.
- R7: done is a single-cycle pulse. Afterwards the block is idle again and keeps byteclk_sel = 1 and ulp_req = 4'h5.
- R8: If entry has not completed, err rises tmo_limit + 2 cycles after ulp_req becomes 4'h5, with err_tmo = 1. From then on, ulp_req, byteclk_sel and pll_en hold their values.
- R9: A request is acted on only in idle. Requests made during a sequence, or while in error, change nothing. The error state is left only through reset.
- R10: A second request after a completed entry fails the R2 precondition check, because ulp_req is no longer 4'h0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte-domain clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Entry request, sampled in idle |
| two_lane | input | 1 | 1 = two data lanes, 0 = one |
| keep_pll | input | 1 | 1 = leave PHY PLL running after entry |
| tmo_limit | input | TMO_W | Allowed wait cycles for lane entry |
| clk_ctl | input | 2 | Current PHY clock-control field |
| trig | input | 4 | Current trigger-request field |
| stat | input | 9 | PHY lane status bits |
| pll_lock | input | 1 | PHY PLL lock flag |
| mux_ack | input | 1 | Byte-clock mux switch acknowledge |
| pll_en_rst | input | 1 | Reset value of pll_en |
| reg_en_rst | input | 1 | Reset value of reg_en |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Sequencer is in error |
| err_tmo | output | 1 | Error cause: 1 = timeout, 0 = precondition |
| byteclk_sel | output | 1 | Byte-clock source: 0 = PHY, 1 = system clock |
| ulp_req | output | 4 | Lane ultra-low-power request field |
| pll_en | output | 1 | PHY PLL enable |
| reg_en | output | 1 | PHY regulator enable |

## Verification
The bench delays the mux acknowledge by several cycles. A design that issued the lane request as soon as it switched the clock would drive ulp_req while the clock was still unconfirmed.

In one-lane mode the bench leaves stat[8:7] set. In two-lane mode it lets only the low lane bits clear. A design that checked the wrong status window would either hang to timeout in one-lane mode or complete falsely in two-lane mode.

Each precondition is broken on its own, including the stop pattern of the other lane count. The timeout distance is measured exactly, so an off-by-one counter shows up. Requests are repeated mid-sequence, in error and after completion; a block that did not ignore them would produce extra outcomes or leave the error state.

// File: rtl/ulp_entry_seq.sv
module ulp_entry_seq #(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             two_lane,
  input  logic             keep_pll,
  input  logic [TMO_W-1:0] tmo_limit,
  input  logic [1:0]       clk_ctl,
  input  logic [3:0]       trig,
  input  logic [8:0]       stat,
  input  logic             pll_lock,
  input  logic             mux_ack,
  input  logic             pll_en_rst,
  input  logic             reg_en_rst,
  output logic             done,
  output logic             err,
  output logic             err_tmo,
  output logic             byteclk_sel,
  output logic [3:0]       ulp_req,
  output logic             pll_en,
  output logic             reg_en
);

  localparam logic [3:0] ENTER_CODE = 4'h5;

  typedef enum logic [2:0] {
    S_IDLE, S_CHECK, S_SWCLK, S_REQ, S_WAIT, S_PLLOFF, S_DONE, S_ERR
  } state_t;

  state_t           state;
  logic [TMO_W-1:0] cnt;
  logic             stop_ok, lanes_ok, pre_ok;

  assign stop_ok  = pll_lock & ~stat[1] &
                    (two_lane ? (stat[8:4] == 5'b11011) : (stat[6:4] == 3'b011));
  assign lanes_ok = two_lane ? (stat[8:1] == 8'h00) : (stat[6:1] == 6'h00);
  assign pre_ok   = (clk_ctl == 2'b11) & pll_en & reg_en &
                    (ulp_req == 4'h0) & (trig == 4'h0) & stop_ok;

  assign done = (state == S_DONE);
  assign err  = (state == S_ERR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      cnt         <= '0;
      err_tmo     <= 1'b0;
      byteclk_sel <= 1'b0;
      ulp_req     <= 4'h0;
      pll_en      <= pll_en_rst;
      reg_en      <= reg_en_rst;
    end else begin
      case (state)
        S_IDLE:  if (req) state <= S_CHECK;
        S_CHECK: begin
          if (pre_ok) begin
            byteclk_sel <= 1'b1;
            state       <= S_SWCLK;
          end else begin
            err_tmo <= 1'b0;
            state   <= S_ERR;
          end
        end
        S_SWCLK: if (mux_ack) begin
          ulp_req <= ENTER_CODE;
          state   <= S_REQ;
        end
        S_REQ: begin
          cnt   <= '0;
          state <= S_WAIT;
        end
        S_WAIT: begin
          if (lanes_ok) begin
            state <= keep_pll ? S_DONE : S_PLLOFF;
          end else if (cnt == tmo_limit) begin
            err_tmo <= 1'b1;
            state   <= S_ERR;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_PLLOFF: begin
          pll_en <= 1'b0;
          state  <= S_DONE;
        end
        S_DONE:  state <= S_IDLE;
        default: state <= S_ERR;
      endcase
    end
  end

  // R4
  clk_before_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ulp_req != 4'h0) |-> byteclk_sel);

  // R4
  req_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ulp_req[0]) |-> $past(mux_ack));

  // R6
  pll_off_late_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pll_en) |-> (ulp_req == ENTER_CODE) && !err && !keep_pll);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !err);

  // R8
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err && $stable(ulp_req) && $stable(byteclk_sel) && $stable(pll_en) && $stable(err_tmo));

  // R2
  pre_err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(err) && !err_tmo) |-> $stable(byteclk_sel) && $stable(ulp_req));

endmodule

// File: tb/tb_ulp_entry_seq.sv
module tb_ulp_entry_seq;
  localparam int CLK_PERIOD = 10;
  localparam int TMO_W = 16;
  localparam int LIMIT = 20;

  logic clk = 0, rst_n = 0, req = 0, two_lane = 0, keep_pll = 0;
  logic [TMO_W-1:0] tmo_limit = LIMIT[TMO_W-1:0];
  logic [1:0] clk_ctl = 2'b11;
  logic [3:0] trig = 4'h0;
  logic [8:0] stat = 9'h030;
  logic pll_lock = 1, mux_ack = 0, pll_en_rst = 1, reg_en_rst = 1;
  logic done, err, err_tmo, byteclk_sel, pll_en, reg_en;
  logic [3:0] ulp_req;

  ulp_entry_seq #(.TMO_W(TMO_W)) dut (
    .clk(clk), .rst_n(rst_n), .req(req), .two_lane(two_lane), .keep_pll(keep_pll),
    .tmo_limit(tmo_limit), .clk_ctl(clk_ctl), .trig(trig), .stat(stat),
    .pll_lock(pll_lock), .mux_ack(mux_ack), .pll_en_rst(pll_en_rst),
    .reg_en_rst(reg_en_rst), .done(done), .err(err), .err_tmo(err_tmo),
    .byteclk_sel(byteclk_sel), .ulp_req(ulp_req), .pll_en(pll_en), .reg_en(reg_en));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  int ev_cnt = 0, ack_delay = 2, phy_delay = 5, ack_cnt = 0, phy_cnt = 0;
  int t_req = 0, t_err = 0;
  logic [8:0] phy_mask = 9'h07E;
  logic ack_hist = 0, order_bad = 0, err_prev = 0;
  logic [3:0] ulp_prev = 0;
  int exp_q[$];

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // stand-in for the clock mux and the PHY lanes
  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      ack_cnt = 0; phy_cnt = 0; mux_ack = 0;
    end else begin
      if (byteclk_sel) begin
        if (ack_cnt >= ack_delay) mux_ack = 1; else ack_cnt++;
      end
      if (ulp_req == 4'h5) begin
        if (phy_cnt >= phy_delay) stat = stat & ~phy_mask; else phy_cnt++;
      end
    end
  end

  always @(posedge clk) if (!rst_n) ack_hist <= 0; else if (mux_ack) ack_hist <= 1;

  // monitor: pops expected outcomes as the design reports them
  always @(negedge clk) begin
    if (!rst_n) begin
      err_prev = 0; ulp_prev = 0; order_bad = 0;
    end else begin
      if (ulp_req != 0 && (!ack_hist || !byteclk_sel)) order_bad = 1;
      if (ulp_req == 4'h5 && ulp_prev == 4'h0) t_req = cyc;
      ulp_prev = ulp_req;
      if (done || (err && !err_prev)) begin
        if (err) t_err = cyc;
        if (exp_q.size() == 0) begin
          chk(0, "R9 unexpected outcome", done ? 0 : (err_tmo ? 2 : 1), -1);
        end else begin
          int e;
          int code;
          e = exp_q.pop_front();
          code = done ? 0 : (err_tmo ? 2 : 1);
          chk(code == e / 2, "R2/R3/R5/R8 outcome kind", code, e / 2);
          chk(pll_en == e[0], "R6 pll_en at outcome", pll_en, e[0]);
          if (code != 1) chk(!order_bad, "R4 clock switch and ack before request", order_bad, 0);
        end
        ev_cnt++;
      end
      err_prev = err;
    end
  end

  task automatic do_reset(input logic pr, input logic rr);
    rst_n = 0; req = 0; pll_en_rst = pr; reg_en_rst = rr;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic setup(input logic two, input logic keep, input logic [8:0] s,
                       input logic [1:0] cc, input logic [3:0] tg, input logic lk,
                       input logic [8:0] mask);
    two_lane = two; keep_pll = keep; stat = s; clk_ctl = cc; trig = tg;
    pll_lock = lk; phy_mask = mask;
  endtask

  task automatic launch(input int code, input logic exp_pll);
    int tgt;
    exp_q.push_back(code * 2 + int'(exp_pll));
    tgt = ev_cnt + 1;
    @(negedge clk) req = 1;
    @(negedge clk) req = 0;
    while (ev_cnt < tgt) @(negedge clk);
  endtask

  initial begin
    // reset state, R1
    do_reset(1, 1);
    chk(byteclk_sel == 0 && ulp_req == 0, "R1 clock select and request after reset", {byteclk_sel, ulp_req}, 0);
    chk(done == 0 && err == 0, "R1 done/err after reset", {done, err}, 0);
    chk(pll_en == 1 && reg_en == 1, "R1 enables follow reset inputs", {pll_en, reg_en}, 3);

    // one-lane full entry with PLL off; second request mid-sequence ignored (R9)
    ack_delay = 6;
    setup(0, 0, 9'h030, 2'b11, 4'h0, 1, 9'h07E);
    fork
      launch(0, 0);
      begin repeat (4) @(negedge clk); req = 1; @(negedge clk); req = 0; end
    join
    chk(ulp_req == 4'h5 && byteclk_sel == 1, "R7 outputs held after done", ulp_req, 5);
    repeat (10) @(negedge clk);
    chk(ev_cnt == 1 && done == 0, "R9 busy request ignored", ev_cnt, 1);
    // R10 second request after completion
    launch(1, 0);

    // two-lane entry with PLL kept
    do_reset(1, 1); ack_delay = 2;
    setup(1, 1, 9'h1B0, 2'b11, 4'h0, 1, 9'h1FE);
    launch(0, 1);
    chk(reg_en == 1, "R6 regulator untouched", reg_en, 1);

    // one-lane ignores stat[8:7] (R5)
    do_reset(1, 1);
    setup(0, 0, 9'h1B0, 2'b11, 4'h0, 1, 9'h07E);
    launch(0, 0);

    // two-lane with upper lane stuck: timeout (R8)
    do_reset(1, 1);
    setup(1, 0, 9'h1B0, 2'b11, 4'h0, 1, 9'h07E);
    launch(2, 1);
    chk(t_err - t_req == LIMIT + 2, "R8 timeout distance", t_err - t_req, LIMIT + 2);
    req = 1; repeat (3) @(negedge clk); req = 0; repeat (3) @(negedge clk);
    chk(err && err_tmo && ulp_req == 4'h5 && byteclk_sel, "R9 error held despite request", {err, err_tmo}, 3);

    // precondition failures, R2 and R3
    do_reset(1, 1); setup(0, 0, 9'h030, 2'b10, 4'h0, 1, 9'h07E); launch(1, 1);
    chk(byteclk_sel == 0 && ulp_req == 0, "R2 no switch on clock-control fail", byteclk_sel, 0);
    do_reset(1, 1); setup(0, 0, 9'h030, 2'b11, 4'h1, 1, 9'h07E); launch(1, 1);
    do_reset(0, 1); setup(0, 0, 9'h030, 2'b11, 4'h0, 1, 9'h07E); launch(1, 0);
    do_reset(1, 0); setup(0, 0, 9'h030, 2'b11, 4'h0, 1, 9'h07E); launch(1, 1);
    do_reset(1, 1); setup(0, 0, 9'h032, 2'b11, 4'h0, 1, 9'h07E); launch(1, 1);
    do_reset(1, 1); setup(0, 0, 9'h030, 2'b11, 4'h0, 0, 9'h07E); launch(1, 1);
    do_reset(1, 1); setup(1, 0, 9'h030, 2'b11, 4'h0, 1, 9'h1FE); launch(1, 1);
    chk(err && !err_tmo && byteclk_sel == 0, "R3 two-lane rejects one-lane pattern", byteclk_sel, 0);

    repeat (5) @(negedge clk);
    chk(exp_q.size() == 0, "R9 all expected outcomes seen", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule